// File: doc/BRIEF.md
# SPI Register-Access Target with In-Band Wait States

This block is a SPI target (clock idle low, data captured on the rising clock edge and changed on the falling one, both directions moving at once) that lets a host read and write a byte-wide register space. Every transfer starts with a four-byte header. The command byte comes first. It carries the direction and the transfer length. Three address bytes follow, with the most significant byte first. The target may then hold the host off by returning single wait bytes. After that it moves between 1 and 64 data bytes, at consecutive register addresses.

The target has no separate busy pin. It tells the host whether it is ready through the least significant bit of each byte it returns. This bit is first checked in the fourth returned byte. If the bit is 0, the host keeps clocking one byte at a time and checks the bit again. The first returned byte with this bit set to 1 ends the wait, and data starts with the byte after it. The wait can only start at the fourth byte. Once it ends, the data phase runs to the end without further pauses.

The register side is a synchronous request/ready interface. A request is held until `reg_ready` is seen high at a clock edge. All SPI pins are oversampled in the system clock domain. Releasing chip-select abandons whatever is in progress.

Top module: `spi_regport`

## Requirements
- R1: The command byte is the first header byte. Bit 7 set means a read and bit 7 clear means a write. Bits 5..0 give the length minus one. The next three header bytes form the 24-bit start address, most significant byte first. Data byte k uses address start+k.
- R2: The first three bytes returned in a transfer are 0x00. The fourth returned byte and every wait byte carry 0 in bits 7..1, and the ready flag in bit 0.
- R3: On a write, if `reg_ready` is high when bit 0 of the fourth returned byte is driven, that bit is 1 and no wait bytes follow. The host's data then begins with its fifth byte.
- R4: Wait bytes (bit 0 = 0) continue while the register side is not ready. For a write, this means `reg_ready` is low. For a read, it means the first data byte has not been fetched. A read always returns 0 in the fourth byte. With `reg_ready` held high, a read has exactly one wait byte. The data phase starts on the byte after the first flag of 1.
- R5: On a write, each data byte produces exactly one accepted `reg_wr` request. That request carries the byte on `reg_wdata` and the address from R1, so a transfer makes exactly len requests.
- R6: On a read, exactly len `reg_rd` requests are accepted. The returned data bytes are the `reg_rdata` values at the addresses from R1, in order, with no gap after the ready byte.
- R7: Command length field 0x00 moves exactly one byte, and 0x3F moves exactly 64 bytes.
- R8: Command bit 6, and any value the host sends during wait bytes (or during a read's data phase), has no effect on the transfer.
- R9: Raising chip-select at any point, including in the middle of a byte, abandons the transfer. A pending write is dropped. The next transfer is decoded from a fresh header and again returns 0x00 in its first three bytes.
- R10: After reset, and while chip-select is high, `spi_miso` is 0 and no register request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| reg_addr | output | 24 | Register address of the current request |
| reg_wdata | output | 8 | Write data byte |
| reg_wr | output | 1 | Write request, held until accepted |
| reg_rd | output | 1 | Read request, held until accepted |
| reg_rdata | input | 8 | Read data, taken in the cycle the read is accepted |
| reg_ready | input | 1 | Register side ready; completes a held request |

## Verification
Two events can land in the same system-clock cycle: the ready-flag decision on the last bit of a status byte, and the register side becoming ready, which for reads also completes the first fetch. The bench makes them collide by releasing `reg_ready` after randomly chosen delays, with ready high from the start, held across the fourth byte, or released partway through the wait bytes. Each result is judged by the same rule. The first returned byte with bit 0 set must be followed at once by correct data, however many wait bytes came before it, and the number of register requests must equal the length.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WAIT = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  localparam int CMD_DIR_BIT = 7;

endpackage

// File: rtl/spi_rt_sync.sv
module spi_rt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);

  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;
  logic              sck_d;

  // Equal-depth pipelines keep MOSI aligned with the SCK edge it belongs to.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck};
      cs_q   <= {cs_q[STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
      sck_d  <= sck_q[STAGES-1];
    end
  end

  assign cs_act   = ~cs_q[STAGES-1];
  assign mosi_s   = mosi_q[STAGES-1];
  assign sck_rise = cs_act &  sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = cs_act & ~sck_q[STAGES-1] &  sck_d;

endmodule

// File: rtl/spi_rt_shift.sv
module spi_rt_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              flag_en,
  input  logic              flag_val,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_start,
  output logic              flag_slot,
  output logic              miso
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_q,  bit_n;
  logic [BYTE_W-1:0] rx_q,   rx_n;
  logic [BYTE_W-1:0] tx_q,   tx_n;

  always_comb begin
    bit_n = bit_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    if (!cs_act) begin
      bit_n = '0;
      rx_n  = '0;
      tx_n  = '0;
    end else begin
      if (sck_rise) begin
        rx_n  = {rx_q[BYTE_W-2:0], mosi_s};
        bit_n = bit_q + 1'b1;
      end
      if (sck_fall) begin
        if (bit_q == '0) begin
          tx_n = load_byte;
        end else if (bit_q == LAST_BIT) begin
          // last bit of the byte: the status flag may replace it
          tx_n = {(flag_en ? flag_val : tx_q[BYTE_W-2]), tx_q[BYTE_W-3:0], 1'b0};
        end else begin
          tx_n = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      bit_q <= bit_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
    end
  end

  assign byte_done  = cs_act & sck_rise & (bit_q == LAST_BIT);
  assign rx_byte    = {rx_q[BYTE_W-2:0], mosi_s};
  assign byte_start = cs_act & sck_fall & (bit_q == '0);
  assign flag_slot  = cs_act & sck_fall & (bit_q == LAST_BIT);
  assign miso       = tx_q[BYTE_W-1];

  // R2: the returned bit only moves on a falling SCK while selected
  a_r2_miso_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sck_fall) |=> $stable(tx_q));

  // R9: deselect leaves the bit position at the start of a byte
  a_r9_deselect_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act) |=> (bit_q == '0 && !miso));

endmodule

// File: rtl/spi_rt_ctrl.sv
module spi_rt_ctrl
  import spi_rt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              byte_start,
  input  logic              flag_slot,
  input  logic              reg_ready,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] load_byte,
  output logic              flag_en,
  output logic              flag_val,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);

  localparam int HDR_BYTES = 1 + ADDR_W / BYTE_W;
  localparam int IDX_W     = $clog2(HDR_BYTES);
  localparam int REM_W     = LEN_W + 1;
  localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_BYTES - 1);
  localparam logic [REM_W-1:0] REM_ONE  = REM_W'(1);

  phase_t            ph_q,    ph_n;
  logic [IDX_W-1:0]  idx_q,   idx_n;
  logic              rd_q,    rd_n;
  logic [REM_W-1:0]  rem_q,   rem_n;
  logic [ADDR_W-1:0] addr_q,  addr_n;
  logic              go_q,    go_n;
  logic [BYTE_W-1:0] buf_q,   buf_n;
  logic              val_q,   val_n;
  logic              rpend_q, rpend_n;
  logic              wpend_q, wpend_n;
  logic [BYTE_W-1:0] wdat_q,  wdat_n;
  logic              accept;

  assign accept   = (rpend_q | wpend_q) & reg_ready;
  assign flag_en  = ((ph_q == PH_HDR) && (idx_q == LAST_HDR)) || (ph_q == PH_WAIT);
  assign flag_val = rd_q ? val_q : reg_ready;

  always_comb begin
    ph_n    = ph_q;
    idx_n   = idx_q;
    rd_n    = rd_q;
    rem_n   = rem_q;
    addr_n  = addr_q;
    go_n    = go_q;
    buf_n   = buf_q;
    val_n   = val_q;
    rpend_n = rpend_q;
    wpend_n = wpend_q;
    wdat_n  = wdat_q;

    // register-side completion
    if (accept) begin
      addr_n = addr_q + 1'b1;
      if (rpend_q) begin
        buf_n   = reg_rdata;
        val_n   = 1'b1;
        rpend_n = 1'b0;
      end else begin
        wpend_n = 1'b0;
      end
    end

    // ready flag decided on the last bit of a status byte
    if (flag_slot && flag_en) begin
      go_n = flag_val;
    end

    if (byte_done) begin
      unique case (ph_q)
        PH_HDR: begin
          idx_n = idx_q + 1'b1;
          if (idx_q == '0) begin
            rd_n  = rx_byte[CMD_DIR_BIT];
            rem_n = REM_W'(rx_byte[LEN_W-1:0]) + REM_ONE;
          end else begin
            addr_n = {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
          end
          if (idx_q == LAST_HDR) begin
            ph_n = go_q ? PH_DATA : PH_WAIT;
            if (rd_q) begin
              rpend_n = 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (go_q) begin
            ph_n = PH_DATA;
          end
        end
        PH_DATA: begin
          if (!rd_q) begin
            wdat_n  = rx_byte;
            wpend_n = 1'b1;
            rem_n   = rem_q - REM_ONE;
            if (rem_q == REM_ONE) begin
              ph_n = PH_DONE;
            end
          end
        end
        default: ;
      endcase
    end

    // read data handed to the shifter; next byte prefetched behind it
    if (byte_start && (ph_q == PH_DATA) && rd_q) begin
      val_n = 1'b0;
      rem_n = rem_q - REM_ONE;
      if (rem_q == REM_ONE) begin
        ph_n = PH_DONE;
      end else begin
        rpend_n = 1'b1;
      end
    end

    if (!cs_act) begin
      ph_n    = PH_HDR;
      idx_n   = '0;
      rd_n    = 1'b0;
      rem_n   = '0;
      addr_n  = '0;
      go_n    = 1'b0;
      buf_n   = '0;
      val_n   = 1'b0;
      rpend_n = 1'b0;
      wpend_n = 1'b0;
      wdat_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_HDR;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
      go_q    <= 1'b0;
      buf_q   <= '0;
      val_q   <= 1'b0;
      rpend_q <= 1'b0;
      wpend_q <= 1'b0;
      wdat_q  <= '0;
    end else begin
      ph_q    <= ph_n;
      idx_q   <= idx_n;
      rd_q    <= rd_n;
      rem_q   <= rem_n;
      addr_q  <= addr_n;
      go_q    <= go_n;
      buf_q   <= buf_n;
      val_q   <= val_n;
      rpend_q <= rpend_n;
      wpend_q <= wpend_n;
      wdat_q  <= wdat_n;
    end
  end

  assign load_byte = ((ph_q == PH_DATA) && rd_q) ? buf_q : '0;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdat_q;
  assign reg_wr    = wpend_q;
  assign reg_rd    = rpend_q;

  // R10: no register request survives a deselect
  a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act) |=> (!reg_rd && !reg_wr));

  // R5: reads and writes are never requested together
  a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  // R1: each completed request advances the address by one
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && (reg_rd || reg_wr) && reg_ready) |=>
      (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

  // R6: the data phase always has bytes left to move
  a_r6_data_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> (rem_q != '0));

  // R4: the go decision only changes at a status-bit slot
  a_r4_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !(flag_slot && flag_en)) |=> $stable(go_q));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W      = 24,
  parameter int BYTE_W      = 8,
  parameter int LEN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_ready
);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              sck_rise, sck_fall, cs_act, mosi_s;
  logic              byte_done, byte_start, flag_slot;
  logic [BYTE_W-1:0] rx_byte, load_byte;
  logic              flag_en, flag_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  spi_rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .mosi_s   (mosi_s)
  );

  spi_rt_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_s),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .mosi_s     (mosi_s),
    .load_byte  (load_byte),
    .flag_en    (flag_en),
    .flag_val   (flag_val),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .byte_start (byte_start),
    .flag_slot  (flag_slot),
    .miso       (spi_miso)
  );

  spi_rt_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .cs_act     (cs_act),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .byte_start (byte_start),
    .flag_slot  (flag_slot),
    .reg_ready  (reg_ready),
    .reg_rdata  (reg_rdata),
    .load_byte  (load_byte),
    .flag_en    (flag_en),
    .flag_val   (flag_val),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd)
  );

endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sck, cs_n, mosi;
  logic        miso;
  logic [23:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd, reg_ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_until = 0;
  int wr_n = 0;
  int rd_n = 0;
  logic [7:0]  mem [256];
  logic [23:0] wlog_a [2048];
  logic [7:0]  wlog_d [2048];

  always #5 clk = ~clk;

  spi_regport u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_ready(reg_ready)
  );

  // register-side model
  assign reg_ready = (cyc >= busy_until);
  assign reg_rdata = mem[reg_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 29 + 7) ^ (i >> 3));
      wr_n <= 0;
      rd_n <= 0;
    end else begin
      if (reg_wr && reg_ready) begin
        mem[reg_addr[7:0]]   <= reg_wdata;
        wlog_a[wr_n & 2047] <= reg_addr;
        wlog_d[wr_n & 2047] <= reg_wdata;
        wr_n <= wr_n + 1;
      end
      if (reg_rd && reg_ready) rd_n <= rd_n + 1;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spi_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send_header(input bit rd, input bit b6, input int len,
                             input logic [23:0] addr, output logic [7:0] r4);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    spi_byte({rd, b6, 6'(len - 1)}, r);
    chk(r == 8'h00, "R2 header byte 1", r, 0);
    spi_byte(addr[23:16], r);
    chk(r == 8'h00, "R2 header byte 2", r, 0);
    spi_byte(addr[15:8], r);
    chk(r == 8'h00, "R2 header byte 3", r, 0);
    spi_byte(addr[7:0], r4);
    chk(r4[7:1] == 7'd0, "R2 fourth byte upper bits", r4, 8'(r4[0]));
  endtask

  task automatic end_cs();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic run_txn(input bit rd, input bit b6, input int len,
                         input logic [23:0] addr, input int busy,
                         output int waits, output logic f4);
    logic [7:0] r, r4, e;
    logic [7:0] wd [64];
    int w0, r0;
    w0 = wr_n;
    r0 = rd_n;
    busy_until = cyc + busy;
    for (int i = 0; i < 64; i++) wd[i] = 8'($urandom);
    send_header(rd, b6, len, addr, r4);
    f4 = r4[0];
    r = r4;
    waits = 0;
    while (!r[0] && waits < 100) begin
      spi_byte(8'($urandom), r);   // R8: host bits during waits are junk
      waits++;
      chk(r[7:1] == 7'd0, "R2 wait byte upper bits", r, 8'(r[0]));
    end
    chk(r[0] == 1'b1, "R4 wait ends with flag 1", r, 1);
    for (int i = 0; i < len; i++) begin
      if (rd) begin
        e = mem[8'(addr + 24'(i))];
        spi_byte(8'($urandom), r);
        chk(r == e, "R6 read data byte", r, e);
      end else begin
        spi_byte(wd[i], r);
      end
    end
    end_cs();
    if (rd) begin
      chk(rd_n - r0 == len, "R6 read request count", rd_n - r0, len);
    end else begin
      chk(wr_n - w0 == len, "R5 write request count", wr_n - w0, len);
      for (int i = 0; i < len && i < wr_n - w0; i++) begin
        chk(wlog_a[(w0 + i) & 2047] == addr + 24'(i), "R1 write address",
            wlog_a[(w0 + i) & 2047], addr + 24'(i));
        chk(wlog_d[(w0 + i) & 2047] == wd[i], "R5 write data",
            wlog_d[(w0 + i) & 2047], wd[i]);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int waits;
    logic f4;
    logic [7:0] r;
    int w0;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    sck = 1'b0;
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk(miso == 1'b0, "R10 miso idle", miso, 0);
    chk(!reg_rd && !reg_wr, "R10 no request", {reg_rd, reg_wr}, 0);

    // R3 write, register side ready: no wait bytes
    run_txn(1'b0, 1'b0, 4, 24'hAABBCC, 0, waits, f4);
    chk(f4 == 1'b1, "R3 write flag in fourth byte", f4, 1);
    chk(waits == 0, "R3 write wait count", waits, 0);

    // R4 read, ready: exactly one wait byte
    run_txn(1'b1, 1'b0, 4, 24'hAABBCC, 0, waits, f4);
    chk(f4 == 1'b0, "R4 read fourth byte flag", f4, 0);
    chk(waits == 1, "R4 read wait count", waits, 1);

    // R4 write held off by busy register side
    run_txn(1'b0, 1'b0, 5, 24'h123400, 800, waits, f4);
    chk(f4 == 1'b0, "R4 busy write fourth byte flag", f4, 0);
    chk(waits >= 1, "R4 busy write waits", waits, 1);

    // R4 read with slow first fetch
    run_txn(1'b1, 1'b0, 5, 24'h123400, 1200, waits, f4);
    chk(waits >= 2, "R4 slow read waits", waits, 2);

    // R7 length extremes, R8 with bit 6 set
    run_txn(1'b0, 1'b1, 64, 24'h0000F0, 0, waits, f4);
    chk(f4 == 1'b1, "R8 bit6 write flag", f4, 1);
    run_txn(1'b1, 1'b1, 64, 24'h0000F0, 0, waits, f4);
    chk(waits == 1, "R8 bit6 read wait count", waits, 1);
    run_txn(1'b0, 1'b0, 1, 24'hFFFFFF, 0, waits, f4);
    run_txn(1'b1, 1'b0, 1, 24'hFFFFFF, 0, waits, f4);
    chk(waits == 1, "R7 single byte read waits", waits, 1);

    // R9 abort during wait bytes of a write: nothing written
    w0 = wr_n;
    busy_until = cyc + 3000;
    send_header(1'b0, 1'b0, 8, 24'h000010, r);
    spi_byte(8'h55, r);
    spi_bits(3);
    end_cs();
    busy_until = cyc;
    repeat (10) @(negedge clk);
    chk(wr_n == w0, "R9 aborted write dropped", wr_n - w0, 0);

    // R9 abort mid data byte of a read, then fresh transfers decode
    send_header(1'b1, 1'b0, 8, 24'h000020, r);
    spi_byte(8'h00, r);
    spi_byte(8'h00, r);
    spi_bits(5);
    end_cs();
    run_txn(1'b0, 1'b0, 3, 24'h000022, 0, waits, f4);
    chk(f4 == 1'b1, "R9 fresh write after abort", f4, 1);
    run_txn(1'b1, 1'b0, 3, 24'h000020, 0, waits, f4);
    chk(waits == 1, "R9 fresh read after abort", waits, 1);

    // randomized transfers
    for (int t = 0; t < 24; t++) begin
      bit rd, b6;
      int len, busy;
      logic [23:0] a;
      rd   = 1'($urandom);
      b6   = 1'($urandom);
      len  = 1 + int'($urandom % 16);
      a    = 24'($urandom);
      busy = ($urandom % 3 == 0) ? 700 + int'($urandom % 600) : 0;
      run_txn(rd, b6, len, a, busy, waits, f4);
      if (rd) begin
        chk(f4 == 1'b0, "R4 random read fourth flag", f4, 0);
        if (busy == 0) chk(waits == 1, "R4 random read waits", waits, 1);
      end else if (busy == 0) begin
        chk(f4 == 1'b1 && waits == 0, "R3 random write no wait", waits, 0);
      end else begin
        chk(f4 == 1'b0, "R4 random busy write flag", f4, 0);
      end
    end

    finish_run();
  end

endmodule